// File: doc/BRIEF.md
# Unipolar Hysteretic Threshold Switch

The block turns a stream of signed digital magnetic field samples into a single active-low switch output. The output turns on (drives 0) when the field rises above a programmable operate threshold. It turns off (drives 1) when the field drops below a release threshold, which sits a selectable hysteresis below the operate threshold. Between the two thresholds the output keeps its last state. This rejects noise and vibration around the switching point.

The operate threshold comes from a 6-bit step code, and the hysteresis from a 2-bit code that indexes a small table. A power-good input starts a fixed power-on window. For the whole window the output is forced on (low), whatever the field does. At the end of the window the output takes a defined state: off if the field lies in the band or below it, and on only if the field is already above the operate threshold. After that the output moves only on a real crossing of a threshold.

Field samples are two's complement, 1 G per LSB. Positive values are south polarity and negative values are north polarity. All comparisons are signed.

Top module: `uni_hyst_switch`

## Requirements
- R1: While rst_ni is low, and in every cycle after an edge at which pwr_good_i was sampled low, switch_n_o is 0 (on).
- R2: After pwr_good_i is first sampled high, switch_n_o stays 0 for POR_CYCLES (default 1250) rising edges, whatever the field value.
- R3: At the first edge after the power-on window, switch_n_o becomes 0 if field_i is strictly above the operate threshold, and 1 otherwise (this includes a field inside the hysteresis band).
- R4: Once powered up, a sample strictly above the operate threshold makes switch_n_o 0 one edge later. A sample equal to the operate threshold does not switch it on.
- R5: Once powered up, a sample strictly below the release threshold makes switch_n_o 1 one edge later.
- R6: Once powered up, a sample between the release and operate thresholds, both included, leaves switch_n_o unchanged.
- R7: The operate threshold is 10 G + 5 G × op_code_i. Code 0 gives 10 G and code 63 gives 325 G.
- R8: The release threshold is the operate threshold minus a hysteresis chosen by hys_code_i: 00 selects 5 G, 01 selects 10 G, 10 selects 20 G and 11 selects 30 G.
- R9: field_i is compared as a signed value. A negative (north) sample can be in the band or below the release threshold, and the most positive sample counts as above the operate threshold.
- R10: Taking pwr_good_i low during operation forces the output on. When pwr_good_i returns high, a full new power-on window and a new first decision (R3) follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply valid indication; low restarts the power-on window |
| field_i | input | 12 | Signed field sample, 1 G per LSB, positive is south |
| op_code_i | input | 6 | Operate threshold step code |
| hys_code_i | input | 2 | Hysteresis selection code |
| switch_n_o | output | 1 | Switch output, 0 = on (field present), 1 = off |

## Verification
The situation hardest to reach from the ports is the first decision at the end of the power-on window. The field value present in that one cycle decides between the in-band default and the switched-on state. A design that starts hysteresis tracking early, or one cycle late, differs only there. The stimulus sweeps the field across far above, far below and in-band values during the window. It then places a chosen value exactly on the cycle the window closes: in band, below release and above operate. It repeats this after dropping power-good mid-operation. A behavioural reference model is compared with the output on every cycle.

// File: rtl/uhs_pkg.sv
package uhs_pkg;
  localparam int unsigned FIELD_W = 12;
  localparam int unsigned THR_W   = FIELD_W + 2;
  localparam int unsigned HYS_N   = 4;

  typedef logic signed [FIELD_W-1:0] field_t;
  typedef logic signed [THR_W-1:0]   thr_t;
endpackage

// File: rtl/uhs_thresh.sv
module uhs_thresh
  import uhs_pkg::*;
#(
  parameter int unsigned OP_W    = 6,
  parameter int          OP_BASE = 10,
  parameter int          OP_STEP = 5,
  parameter logic [HYS_N-1:0][FIELD_W-1:0] HYS_TAB = {12'd30, 12'd20, 12'd10, 12'd5}
) (
  input  logic [OP_W-1:0]          op_code_i,
  input  logic [$clog2(HYS_N)-1:0] hys_code_i,
  output thr_t                     op_thr_o,
  output thr_t                     rel_thr_o
);
  thr_t hys_sel;

  // table index mux, one arm per entry
  always_comb begin
    hys_sel = '0;
    for (int i = 0; i < HYS_N; i++) begin
      if (hys_code_i == i[$clog2(HYS_N)-1:0]) hys_sel = thr_t'(HYS_TAB[i]);
    end
  end

  assign op_thr_o  = thr_t'(OP_BASE) + thr_t'(OP_STEP) * thr_t'(op_code_i);
  assign rel_thr_o = op_thr_o - hys_sel;
endmodule

// File: rtl/uhs_por_timer.sv
module uhs_por_timer #(
  parameter int unsigned POR_CYCLES = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic ready_o
);
  localparam int unsigned   CNT_W   = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(POR_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             done;

  assign done = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!pwr_good_i) cnt_q <= '0;
    else if (!done)       cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = pwr_good_i & done;
endmodule

// File: rtl/uhs_switch_core.sv
module uhs_switch_core
  import uhs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ready_i,
  input  field_t field_i,
  input  thr_t   op_thr_i,
  input  thr_t   rel_thr_i,
  output logic   on_o
);
  logic on_q, arm_q;
  logic above, below;

  assign above = thr_t'(field_i) > op_thr_i;
  assign below = thr_t'(field_i) < rel_thr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b1;
      arm_q <= 1'b1;
    end else if (!ready_i) begin
      on_q  <= 1'b1;           // forced on during power-on window
      arm_q <= 1'b1;
    end else if (arm_q) begin
      on_q  <= above;          // in-band default is off
      arm_q <= 1'b0;
    end else if (above) begin
      on_q  <= 1'b1;
    end else if (below) begin
      on_q  <= 1'b0;
    end
  end

  assign on_o = on_q;
endmodule

// File: rtl/uni_hyst_switch.sv
module uni_hyst_switch #(
  parameter int unsigned POR_CYCLES = 1250,
  parameter int unsigned OP_W       = 6,
  parameter int          OP_BASE    = 10,
  parameter int          OP_STEP    = 5,
  parameter logic [uhs_pkg::HYS_N-1:0][uhs_pkg::FIELD_W-1:0] HYS_TAB =
    {12'd30, 12'd20, 12'd10, 12'd5}
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                pwr_good_i,
  input  logic signed [uhs_pkg::FIELD_W-1:0]  field_i,
  input  logic [OP_W-1:0]                     op_code_i,
  input  logic [$clog2(uhs_pkg::HYS_N)-1:0]   hys_code_i,
  output logic                                switch_n_o
);
  import uhs_pkg::*;

  thr_t op_thr, rel_thr;
  logic por_ready;
  logic sw_on;

  uhs_thresh #(
    .OP_W(OP_W), .OP_BASE(OP_BASE), .OP_STEP(OP_STEP), .HYS_TAB(HYS_TAB)
  ) u_thresh (
    .op_code_i (op_code_i),
    .hys_code_i(hys_code_i),
    .op_thr_o  (op_thr),
    .rel_thr_o (rel_thr)
  );

  uhs_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .ready_o   (por_ready)
  );

  uhs_switch_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ready_i  (por_ready),
    .field_i  (field_i),
    .op_thr_i (op_thr),
    .rel_thr_i(rel_thr),
    .on_o     (sw_on)
  );

  assign switch_n_o = ~sw_on;
endmodule

// File: rtl/uhs_checker.sv
module uhs_checker
  import uhs_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   pwr_good_i,
  input field_t field_i,
  input logic   switch_n_o,
  input logic   ready_i,
  input thr_t   op_thr_i,
  input thr_t   rel_thr_i
);
  logic above, below, in_band;
  assign above   = thr_t'(field_i) > op_thr_i;
  assign below   = thr_t'(field_i) < rel_thr_i;
  assign in_band = !above && !below;

  p_unpowered_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !switch_n_o);

  p_window_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> !switch_n_o);

  p_first_default_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_i) && !above) |=> switch_n_o);

  p_above_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && above) |=> !switch_n_o);

  p_below_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && below) |=> switch_n_o);

  p_band_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && $past(ready_i) && in_band) |=> $stable(switch_n_o));

  always_comb begin
    if (rst_ni) begin
      p_rel_below_op_r8: assert (rel_thr_i < op_thr_i);
    end
  end
endmodule

bind uni_hyst_switch uhs_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_good_i(pwr_good_i),
  .field_i   (field_i),
  .switch_n_o(switch_n_o),
  .ready_i   (por_ready),
  .op_thr_i  (op_thr),
  .rel_thr_i (rel_thr)
);

// File: tb/uni_hyst_switch_test.sv
`timescale 1ns/1ps
module uni_hyst_switch_test;
  localparam int POR = 1250;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pg = 1'b0;
  logic signed [11:0] field = '0;
  logic [5:0]        code = '0;
  logic [1:0]        hys = '0;
  logic              sw_n;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  uni_hyst_switch uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .field_i(field),
    .op_code_i(code), .hys_code_i(hys), .switch_n_o(sw_n)
  );

  function automatic int hys_g(logic [1:0] h);
    case (h)
      2'd0: return 5;
      2'd1: return 10;
      2'd2: return 20;
      default: return 30;
    endcase
  endfunction

  // behavioural reference
  int m_cnt;
  bit m_on, m_arm;
  always @(posedge clk or negedge rst_n) begin : mdl
    int op, rel, f;
    bit rdy;
    if (!rst_n) begin
      m_cnt = 0; m_on = 1; m_arm = 1;
    end else begin
      op  = 10 + 5 * int'(code);
      rel = op - hys_g(hys);
      f   = int'(field);
      rdy = pg && (m_cnt == POR);
      if (!rdy) begin m_on = 1; m_arm = 1; end
      else if (m_arm) begin m_on = (f > op); m_arm = 0; end
      else if (f > op) m_on = 1;
      else if (f < rel) m_on = 0;
      if (!pg) m_cnt = 0;
      else if (m_cnt < POR) m_cnt++;
    end
  end

  always @(negedge clk) begin
    total++;
    if (sw_n !== !m_on) begin
      bad++;
      $display("FAIL %s model compare: actual=%b expected=%b t=%0t", cur_req, sw_n, !m_on, $time);
    end
  end

  task automatic chk(logic exp, string req);
    total++;
    if (sw_n !== exp) begin
      bad++;
      $display("FAIL %s directed: actual=%b expected=%b t=%0t", req, sw_n, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    chk(1'b0, "R1");
    rst_n = 1'b1; field = 12'sd500;
    step(5);
    chk(1'b0, "R1");

    // power-on window, field swept, in-band at expiry
    cur_req = "R2";
    pg = 1'b1;
    step(600); field = -12'sd300;
    step(300); field = 12'sd400;
    step(POR - 900);
    chk(1'b0, "R2");
    cur_req = "R3"; field = 12'sd8;
    step(1); chk(1'b1, "R3");

    cur_req = "R6"; field = 12'sd10; step(2); chk(1'b1, "R6");
    cur_req = "R4"; field = 12'sd11; step(1); chk(1'b0, "R4");
    cur_req = "R6"; field = 12'sd5;  step(3); chk(1'b0, "R6");
    cur_req = "R5"; field = 12'sd4;  step(1); chk(1'b1, "R5");

    cur_req = "R7"; code = 6'd20;
    field = 12'sd110; step(2); chk(1'b1, "R7");
    field = 12'sd111; step(1); chk(1'b0, "R7");
    cur_req = "R8"; hys = 2'd3;
    field = 12'sd80; step(2); chk(1'b0, "R8");
    field = 12'sd79; step(1); chk(1'b1, "R8");
    field = 12'sd111; step(1); chk(1'b0, "R4");
    hys = 2'd1;
    field = 12'sd100; step(2); chk(1'b0, "R8");
    field = 12'sd99;  step(1); chk(1'b1, "R8");
    cur_req = "R7"; code = 6'd63;
    field = 12'sd325; step(2); chk(1'b1, "R7");
    field = 12'sd326; step(1); chk(1'b0, "R7");

    cur_req = "R9"; code = 6'd0; hys = 2'd2;
    field = -12'sd10; step(2); chk(1'b0, "R9");
    field = -12'sd11; step(1); chk(1'b1, "R9");
    field = -12'sd2048; step(2); chk(1'b1, "R9");
    field = 12'sd2047; step(1); chk(1'b0, "R9");
    field = -12'sd11; step(1); chk(1'b1, "R9");

    cur_req = "R10";
    pg = 1'b0; step(1); chk(1'b0, "R10");
    step(4); chk(1'b0, "R1");
    pg = 1'b1; step(POR); chk(1'b0, "R10");
    step(1); chk(1'b1, "R10");

    cur_req = "R3";
    pg = 1'b0; step(2);
    field = 12'sd50; pg = 1'b1;
    step(POR); chk(1'b0, "R2");
    step(1); chk(1'b0, "R3");
    cur_req = "R6"; field = 12'sd0; step(3); chk(1'b0, "R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule